// File: doc/BRIEF.md
# Trace Timestamp Reconstruction Unit

The unit takes a stream of trace timing packets that have already been decoded and keeps a running estimate of the full wall-clock timestamp. Five packet kinds are used. A full-timestamp packet loads the base value. The alignment packet that follows it records where that timestamp fell in the 16-bit crystal-clock phase, and how far it lay into the next crystal clock. Periodic crystal-tick packets move the estimate forward by whole crystal clocks. Between ticks, cycle-count packets refine the estimate: their sum is scaled by a static reference multiplier and divided by the latest core:bus ratio.

The internal state is split into three parts: an anchor at the last crystal edge, a fractional offset, and a scaled cycle term. The estimate on the output is the sum of these three parts, so it moves with every accepted packet. A crystal tick folds the fine terms into the anchor and clears them, so errors from cycle counting do not build up from one tick to the next. The number of timestamp units per crystal clock and the tick-frequency exponent are configuration inputs.

Top module: `ts_rebuild`

## Requirements
- R1: After reset, `ts_valid` and `upd_stb` are 0 and `ts_est` is 0.
- R2: Kind 0 (full timestamp, value in payload[63:0]) sets `ts_est` to the payload on the next cycle. It clears the fractional offset and the cycle sum, and it drops the crystal-phase reference.
- R3: `ts_valid` rises only on the cycle after a kind 1 packet (alignment: phase in payload[15:0], fractional offset in payload[31:16]) that follows a kind 0 packet. A kind 1 packet with no kind 0 packet pending since the last alignment is ignored.
- R4: An accepted alignment packet leaves `ts_est` unchanged. It arms the phase reference and moves the fractional offset out of the anchor.
- R5: Kind 2 (crystal tick, field in payload[15:8]) with an armed reference works as follows. The new phase is (field << `tick_exp`) truncated to 16 bits. `ts_est` becomes anchor + ((phase − reference) mod 2^16) × `xtal_mult`. The fractional offset and the cycle sum are cleared, and the reference becomes the new phase.
- R6: The phase difference of a tick wraps modulo 2^16 when the new phase is below the reference.
- R7: A tick that arrives while no reference is armed (after reset, or after a full timestamp and before its alignment) leaves `ts_est` unchanged.
- R8: Kind 3 (cycle count, payload[23:0]) adds to the cycle sum. `ts_est` = anchor + fraction + floor(sum × `p1_ratio` / ratio), using the latest kind 4 (ratio, payload[7:0]) value.
- R9: While the stored ratio is 0, the cycle sum adds nothing to `ts_est`.
- R10: The cycle sum saturates at 2^24 − 1 and does not wrap.
- R11: `upd_stb` is high for exactly the cycle after each packet of kind 0 to 4. Kinds 5 to 7 give no strobe and change nothing.
- R12: Once `ts_valid` is high it stays high, including across later full-timestamp packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | A packet is present this cycle |
| pkt_kind | input | 3 | Packet kind: 0 full, 1 align, 2 tick, 3 cycles, 4 ratio |
| pkt_payload | input | 64 | Packet payload |
| tick_exp | input | 4 | Left shift applied to the tick field |
| p1_ratio | input | 8 | Reference-frequency multiplier for cycle counts |
| xtal_mult | input | 16 | Timestamp units per crystal clock |
| ts_est | output | 64 | Timestamp estimate |
| ts_valid | output | 1 | The estimate is anchored to a timestamp/alignment pair |
| upd_stb | output | 1 | One-cycle pulse after each accepted packet |

## Verification
A wrong phase reference does not show until the next tick. That tick then moves `ts_est` by a wrong multiple of `xtal_mult`, one cycle after it arrives. The tests therefore send back-to-back ticks, including one that wraps, and check the exact sums. A stale cycle sum or ratio shows on the cycle right after any cycle-count or ratio packet. A missed clear shows after the next full timestamp, because a leftover scaled term then offsets the reloaded value. Flag errors in the valid/reference logic show either as `ts_valid` rising too early or as a tick moving the estimate when it should be held.

// File: rtl/ts_rebuild_pkg.sv
package ts_rebuild_pkg;

   typedef enum logic [2:0] {
      PK_FULL  = 3'd0,
      PK_ALIGN = 3'd1,
      PK_TICK  = 3'd2,
      PK_CYC   = 3'd3,
      PK_RATIO = 3'd4
   } pkt_kind_e;

   localparam int unsigned TICK_LSB   = 8;
   localparam int unsigned TICK_BITS  = 8;

endpackage

// File: rtl/tsr_tick_calc.sv
module tsr_tick_calc #(
   parameter int unsigned XTAL_W = 16,
   parameter int unsigned EXP_W  = 4,
   parameter int unsigned MULT_W = 16,
   parameter int unsigned FLD_W  = 8,
   localparam int unsigned PROD_W = XTAL_W + MULT_W
) (
   input  logic [FLD_W-1:0]  field_i,
   input  logic [EXP_W-1:0]  exp_i,
   input  logic [XTAL_W-1:0] ref_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic [XTAL_W-1:0] phase_o,
   output logic [PROD_W-1:0] step_o
);

   if (XTAL_W < FLD_W) begin : g_bad_xtal
      $error("tsr_tick_calc: XTAL_W must cover the tick field");
   end

   logic [XTAL_W-1:0] field_ext;
   logic [XTAL_W-1:0] delta;

   always_comb begin
      field_ext = {{(XTAL_W-FLD_W){1'b0}}, field_i};
      phase_o   = field_ext << exp_i;
      delta     = phase_o - ref_i;
      step_o    = PROD_W'(delta) * PROD_W'(mult_i);
   end

endmodule

// File: rtl/tsr_cyc_accum.sv
module tsr_cyc_accum #(
   parameter int unsigned CYC_W    = 24,
   parameter int unsigned P1_W     = 8,
   parameter int unsigned RATIO_W  = 8,
   parameter bit          SAT_EN   = 1'b1,
   parameter bit          SCALE_EN = 1'b1,
   localparam int unsigned SCL_W   = CYC_W + P1_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               add_i,
   input  logic [CYC_W-1:0]   add_val_i,
   input  logic               ratio_we_i,
   input  logic [RATIO_W-1:0] ratio_val_i,
   input  logic [P1_W-1:0]    p1_i,
   output logic [SCL_W-1:0]   scaled_o,
   output logic               ratio_zero_o
);

   logic [CYC_W-1:0]   acc_q;
   logic [CYC_W-1:0]   acc_sum;
   logic [RATIO_W-1:0] ratio_q;

   if (SAT_EN) begin : g_sat
      logic [CYC_W:0] wide;
      always_comb begin
         wide    = {1'b0, acc_q} + {1'b0, add_val_i};
         acc_sum = wide[CYC_W] ? {CYC_W{1'b1}} : wide[CYC_W-1:0];
      end
      // R10
      acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_i |=> acc_q >= $past(acc_q));
   end else begin : g_wrap
      always_comb acc_sum = acc_q + add_val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         ratio_q <= '0;
      end else begin
         if (clr_i)      acc_q <= '0;
         else if (add_i) acc_q <= acc_sum;
         if (ratio_we_i) ratio_q <= ratio_val_i;
      end
   end

   assign ratio_zero_o = (ratio_q == '0);

   if (SCALE_EN) begin : g_scale
      logic [SCL_W-1:0] prod;
      always_comb begin
         prod     = SCL_W'(acc_q) * SCL_W'(p1_i);
         scaled_o = ratio_zero_o ? '0 : prod / SCL_W'(ratio_q);
      end
   end else begin : g_noscale
      assign scaled_o = '0;
   end

   // R2
   clr_scaled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> scaled_o == '0);

endmodule

// File: rtl/ts_rebuild.sv
module ts_rebuild
   import ts_rebuild_pkg::*;
#(
   parameter int unsigned TS_W     = 64,
   parameter int unsigned XTAL_W   = 16,
   parameter int unsigned FAST_W   = 16,
   parameter int unsigned EXP_W    = 4,
   parameter int unsigned MULT_W   = 16,
   parameter int unsigned CYC_W    = 24,
   parameter int unsigned P1_W     = 8,
   parameter int unsigned RATIO_W  = 8,
   parameter bit          SAT_EN   = 1'b1,
   parameter bit          SCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [2:0]        pkt_kind,
   input  logic [TS_W-1:0]   pkt_payload,
   input  logic [EXP_W-1:0]  tick_exp,
   input  logic [P1_W-1:0]   p1_ratio,
   input  logic [MULT_W-1:0] xtal_mult,
   output logic [TS_W-1:0]   ts_est,
   output logic              ts_valid,
   output logic              upd_stb
);

   localparam int unsigned PROD_W = XTAL_W + MULT_W;
   localparam int unsigned SCL_W  = CYC_W + P1_W;

   if (XTAL_W + FAST_W > TS_W) begin : g_bad_align
      $error("ts_rebuild: alignment fields exceed payload");
   end
   if (SCL_W > TS_W || PROD_W > TS_W) begin : g_bad_scale
      $error("ts_rebuild: scaled terms exceed timestamp width");
   end
   if (CYC_W > TS_W || RATIO_W > TS_W) begin : g_bad_cyc
      $error("ts_rebuild: cycle fields exceed payload");
   end

   logic is_full, is_align, is_tick, is_cyc, is_ratio, known;
   always_comb begin
      is_full  = pkt_valid && (pkt_kind == PK_FULL);
      is_align = pkt_valid && (pkt_kind == PK_ALIGN);
      is_tick  = pkt_valid && (pkt_kind == PK_TICK);
      is_cyc   = pkt_valid && (pkt_kind == PK_CYC);
      is_ratio = pkt_valid && (pkt_kind == PK_RATIO);
      known    = is_full | is_align | is_tick | is_cyc | is_ratio;
   end

   logic [TS_W-1:0]   anchor_q;
   logic [FAST_W-1:0] frac_q;
   logic [XTAL_W-1:0] ref_q;
   logic              pend_q, ref_ok_q, valid_q, stb_q;

   logic [XTAL_W-1:0] phase_now;
   logic [PROD_W-1:0] step;
   logic [FAST_W-1:0] fast_in;
   logic              align_ok, tick_ok;

   assign fast_in  = pkt_payload[XTAL_W +: FAST_W];
   assign align_ok = is_align && pend_q;
   assign tick_ok  = is_tick && ref_ok_q;

   tsr_tick_calc #(
      .XTAL_W (XTAL_W),
      .EXP_W  (EXP_W),
      .MULT_W (MULT_W),
      .FLD_W  (TICK_BITS)
   ) u_tick (
      .field_i (pkt_payload[TICK_LSB +: TICK_BITS]),
      .exp_i   (tick_exp),
      .ref_i   (ref_q),
      .mult_i  (xtal_mult),
      .phase_o (phase_now),
      .step_o  (step)
   );

   logic [SCL_W-1:0] scaled;
   logic             ratio_zero;

   tsr_cyc_accum #(
      .CYC_W    (CYC_W),
      .P1_W     (P1_W),
      .RATIO_W  (RATIO_W),
      .SAT_EN   (SAT_EN),
      .SCALE_EN (SCALE_EN)
   ) u_cyc (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (is_full | tick_ok),
      .add_i        (is_cyc),
      .add_val_i    (pkt_payload[CYC_W-1:0]),
      .ratio_we_i   (is_ratio),
      .ratio_val_i  (pkt_payload[RATIO_W-1:0]),
      .p1_i         (p1_ratio),
      .scaled_o     (scaled),
      .ratio_zero_o (ratio_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         anchor_q <= '0;
         frac_q   <= '0;
         ref_q    <= '0;
         pend_q   <= 1'b0;
         ref_ok_q <= 1'b0;
         valid_q  <= 1'b0;
         stb_q    <= 1'b0;
      end else begin
         stb_q <= known;
         if (is_full) begin
            anchor_q <= pkt_payload;
            frac_q   <= '0;
            pend_q   <= 1'b1;
            ref_ok_q <= 1'b0;
         end else if (align_ok) begin
            anchor_q <= anchor_q - TS_W'(fast_in);
            frac_q   <= fast_in;
            ref_q    <= pkt_payload[XTAL_W-1:0];
            pend_q   <= 1'b0;
            ref_ok_q <= 1'b1;
            valid_q  <= 1'b1;
         end else if (tick_ok) begin
            anchor_q <= anchor_q + TS_W'(step);
            frac_q   <= '0;
            ref_q    <= phase_now;
         end
      end
   end

   assign ts_est   = anchor_q + TS_W'(frac_q) + TS_W'(scaled);
   assign ts_valid = valid_q;
   assign upd_stb  = stb_q;

   // R11
   stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> $past(pkt_valid));
   // R12
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |=> ts_valid);
   // R3
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts_valid) |-> $past(pkt_valid && pkt_kind == PK_ALIGN));
   // R9
   zero_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cyc && ratio_zero) |=> $stable(ts_est));
   // R7
   orphan_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_tick && !ref_ok_q) |=> $stable(ts_est));
   // R4
   align_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_ok |=> $stable(ts_est));

endmodule

// File: tb/sim_ts_rebuild.sv
`timescale 1ns/1ps
module sim_ts_rebuild;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [2:0]  pkt_kind = 3'd0;
   logic [63:0] pkt_payload = '0;
   logic [3:0]  tick_exp = 4'd0;
   logic [7:0]  p1_ratio = 8'd10;
   logic [15:0] xtal_mult = 16'd4;
   logic [63:0] ts_est;
   logic        ts_valid;
   logic        upd_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ts_rebuild u0 (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
      .pkt_payload(pkt_payload), .tick_exp(tick_exp), .p1_ratio(p1_ratio),
      .xtal_mult(xtal_mult), .ts_est(ts_est), .ts_valid(ts_valid), .upd_stb(upd_stb)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic send(input logic [2:0] kind, input logic [63:0] pay);
      @(negedge clk);
      pkt_valid   = 1'b1;
      pkt_kind    = kind;
      pkt_payload = pay;
      @(negedge clk);
      pkt_valid   = 1'b0;
      pkt_payload = '0;
   endtask

   task automatic t_reset;
      chk("R1 valid", {63'd0, ts_valid}, 64'd0);
      chk("R1 stb", {63'd0, upd_stb}, 64'd0);
      chk("R1 est", ts_est, 64'd0);
   endtask

   task automatic t_orphan;
      send(3'd1, 64'h0003_0010);
      chk("R3 orphan align valid", {63'd0, ts_valid}, 64'd0);
      chk("R3 orphan align est", ts_est, 64'd0);
      send(3'd2, 64'h2000);
      chk("R7 tick before reference", ts_est, 64'd0);
      send(3'd6, 64'd777);
      chk("R11 unknown kind stb", {63'd0, upd_stb}, 64'd0);
      chk("R11 unknown kind est", ts_est, 64'd0);
   endtask

   task automatic t_pair;
      send(3'd0, 64'd1000);
      chk("R2 base load", ts_est, 64'd1000);
      chk("R11 strobe", {63'd0, upd_stb}, 64'd1);
      chk("R3 valid low before align", {63'd0, ts_valid}, 64'd0);
      send(3'd2, 64'h2000);
      chk("R7 tick before align", ts_est, 64'd1000);
      send(3'd1, 64'h0003_0010);
      chk("R4 align keeps est", ts_est, 64'd1000);
      chk("R3 valid after pair", {63'd0, ts_valid}, 64'd1);
      @(negedge clk);
      chk("R11 strobe one cycle", {63'd0, upd_stb}, 64'd0);
   endtask

   task automatic t_tick;
      send(3'd2, 64'h2000);
      chk("R5 first tick", ts_est, 64'd1061);
   endtask

   task automatic t_cycles;
      send(3'd4, 64'd5);
      chk("R8 ratio load no sum", ts_est, 64'd1061);
      send(3'd3, 64'd7);
      chk("R8 cycles 7", ts_est, 64'd1075);
      send(3'd3, 64'd3);
      chk("R8 cycles sum 10", ts_est, 64'd1081);
      tick_exp = 4'd2;
      send(3'd2, 64'h0C00);
      chk("R5 tick folds cycles", ts_est, 64'd1125);
   endtask

   task automatic t_wrap;
      tick_exp = 4'd0;
      send(3'd2, 64'h1000);
      chk("R6 wrapped delta", ts_est, 64'd263141);
   endtask

   task automatic t_zero_ratio;
      send(3'd4, 64'd0);
      send(3'd3, 64'd50);
      chk("R9 zero ratio", ts_est, 64'd263141);
      send(3'd4, 64'd5);
      chk("R8 ratio applied to sum", ts_est, 64'd263241);
   endtask

   task automatic t_saturate;
      send(3'd4, 64'd1);
      chk("R8 ratio one", ts_est, 64'd263641);
      send(3'd3, 64'hFF_FFFF);
      chk("R10 saturate", ts_est, 64'd168035291);
      send(3'd3, 64'd5);
      chk("R10 held at max", ts_est, 64'd168035291);
   endtask

   task automatic t_reload;
      send(3'd0, 64'd5000);
      chk("R2 reload clears cycles", ts_est, 64'd5000);
      chk("R12 valid kept", {63'd0, ts_valid}, 64'd1);
      send(3'd2, 64'h4000);
      chk("R7 tick after reload", ts_est, 64'd5000);
      send(3'd7, 64'd99);
      chk("R11 kind 7 est", ts_est, 64'd5000);
      chk("R11 kind 7 stb", {63'd0, upd_stb}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_orphan();
      t_pair();
      t_tick();
      t_cycles();
      t_wrap();
      t_zero_ratio();
      t_saturate();
      t_reload();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule